// File: doc/BRIEF.md
# Bus Machine-Cycle Sequencer

This block runs one external bus machine cycle at a time for an 8-bit processor core. The core names a cycle kind, a 16-bit address and write data. The block then steps through the T-states of that cycle and drives the active-low memory-request, I/O-request, read, write, first-cycle and refresh strobes. It also drives the address bus and the outgoing data byte, each with an enable. It samples the incoming data byte and the active-low wait input. An opcode fetch ends with two T-states in which a transparent refresh access for dynamic memory runs off a 7-bit counter held in the block. I/O and interrupt-acknowledge cycles add their own fixed wait states.

Each T-state takes two cycles of `clk`: a first half and a second half. This lets strobes start "half a clock" into a T-state while the whole design stays on one clock edge. A high `req_valid` in an idle clock starts the cycle: T1 begins on the next clock. `done` marks the final half-state, and the clock after it is always idle. Kind codes are 0 for opcode fetch, 1 for memory read, 2 for memory write, 3 for I/O read, 4 for I/O write and 5 for interrupt acknowledge. Codes 6 and 7 run as memory reads. The address and data enables stand in for high impedance. When an enable is low, the matching output is driven to zero.

Top module: `bus_cycle_seq`

## Requirements
- R1: Opcode fetch (kind 0). During all of T1, `addr` equals the request address with `addr_oe` high, and `m1_n` is low. From the second half of T1 through T2 and any wait states, `mreq_n`, `rd_n` and `m1_n` are all low. From T3 onward `m1_n` is high.
- R2: A fetch samples `dbus_in` at the clock edge that begins T3. The sampled byte is on `rdata` while `done` is high.
- R3: Throughout T3 and T4 of a fetch, `rfsh_n` is low and `rd_n` is high. `addr` carries the 8-bit refresh value, zero-extended. `mreq_n` is low only in the second half of T3 and the first half of T4.
- R4: The refresh value resets to 0. After each fetch its low 7 bits step up by one, modulo 128, and bit 7 keeps its value. This makes bit 7 of the refresh address 0 and wraps 127 to 0.
- R5: Memory read (kind 1, and also kinds 6 and 7). `mreq_n` and `rd_n` are low from the second half of T1 to the end of the first half of T3. `dbus_in` is sampled at the edge that ends the first half of T3.
- R6: Memory write (kind 2). `dbus_oe` is high, with `dbus_out` equal to the write byte, from the second half of T1 to the end of T3. `mreq_n` is low from the second half of T1 to the end of the first half of T3. `wr_n` is low only from the second half of T2 to the end of the first half of T3.
- R7: I/O read (kind 3) and I/O write (kind 4) keep `mreq_n` high. They drive `iorq_n` low, with `rd_n` low for a read or `wr_n` low for a write, from the start of T2 to the end of the first half of T3. One automatic wait state always follows T2. Write data is enabled from the second half of T1 to the end of T3. Read data is sampled at the end of the first half of T3.
- R8: Interrupt acknowledge (kind 5) keeps `mreq_n`, `rd_n` and `wr_n` high. It adds two automatic wait states after T2. `m1_n` is low from T1 to the end of the first half of T3. `iorq_n` is low from the start of the second automatic wait state to the end of the first half of T3. The vector on `dbus_in` is sampled at the end of the first half of T3.
- R9: `wait_n` is sampled at the edge that ends the last state before T3, meaning T2 or the last automatic wait state, and at the edge that ends each inserted wait state. A low sample inserts a wait state. During that wait state the strobes, `addr`, `addr_oe` and `dbus_oe` keep the values they had in the preceding half-state.
- R10: In the clock after any clock with `rst` high, all six strobes are high and `addr_oe`, `dbus_oe` and `done` are low. Reset also clears the refresh value. The system holds `rst` for at least 3 clocks.
- R11: If `halt_i` is high in an idle clock with no request, a fetch cycle starts at `req_addr`. This keeps refresh accesses running while the core is halted.
- R12: `done` is high for exactly one clock: the second half of T4 for a fetch, or the second half of T3 for any other kind. The next clock is idle, with every strobe inactive and both enables low. A request in that idle clock starts T1 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is half a T-state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a cycle; looked at in idle clocks only |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Memory address, port number or program counter |
| req_wdata | input | 8 | Byte to write |
| halt_i | input | 1 | Core halted: run fetch cycles with no request |
| wait_n | input | 1 | Active-low not-ready from memory or I/O |
| dbus_in | input | 8 | Incoming data bus byte |
| rdata | output | 8 | Last sampled read byte, opcode or vector |
| done | output | 1 | Final half-state of the machine cycle |
| addr | output | 16 | Address bus |
| addr_oe | output | 1 | Address bus enable |
| dbus_out | output | 8 | Outgoing data bus byte |
| dbus_oe | output | 1 | Outgoing data enable |
| mreq_n | output | 1 | Memory request, active low |
| iorq_n | output | 1 | I/O request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m1_n | output | 1 | First-cycle (fetch/acknowledge) marker, active low |
| rfsh_n | output | 1 | Refresh access marker, active low |

## Verification
All outputs are decoded from registered state, so every half-state's strobes are due in the very clock that half-state occupies. T1 begins exactly one clock after the idle clock that carried the request. The bench builds its own list of half-states from the kind and the planned number of wait states. It compares strobes, enables, address and data at the falling edge in the middle of each clock. It drives `wait_n` and `dbus_in` at the falling edge just before the rising edge where each is due to be sampled. The correct byte is on `dbus_in` only in the clock ahead of that sampling edge, and the complement is there at every other time, so data sampled one clock early or late shows up on `rdata` in the `done` clock. The refresh address expected in T3 and T4 comes from a counter the bench steps after each fetch it drives.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int ADDR_W_DEF = 16;
    localparam int DATA_W_DEF = 8;
    localparam int RCNT_W_DEF = 7;

    typedef enum logic [2:0] {
        CK_FETCH = 3'd0,
        CK_MRD   = 3'd1,
        CK_MWR   = 3'd2,
        CK_IORD  = 3'd3,
        CK_IOWR  = 3'd4,
        CK_INTA  = 3'd5
    } cyc_kind_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_TA1  = 3'd3,
        TS_TA2  = 3'd4,
        TS_TW   = 3'd5,
        TS_T3   = 3'd6,
        TS_T4   = 3'd7
    } tstate_e;

    // Internal strobe set, active high.
    typedef struct packed {
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
        logic m1;
        logic rfsh;
        logic aoe;
        logic doe;
        logic done;
    } strobe_s;

    function automatic cyc_kind_e norm_kind(logic [2:0] raw);
        if (raw > 3'd5) begin
            return CK_MRD;
        end
        return cyc_kind_e'(raw);
    endfunction

    function automatic logic kind_has_auto_wait(cyc_kind_e k);
        return (k == CK_IORD) || (k == CK_IOWR) || (k == CK_INTA);
    endfunction

    function automatic logic kind_reads(cyc_kind_e k);
        return (k == CK_MRD) || (k == CK_IORD) || (k == CK_INTA);
    endfunction

    // Strobe pattern for a given kind, T-state and half (ph = 1: second half).
    function automatic strobe_s strobe_table(cyc_kind_e k, tstate_e t, logic ph);
        strobe_s s;
        s = '0;
        case (k)
            CK_FETCH: begin
                case (t)
                    TS_T1: begin
                        s.aoe = 1'b1; s.m1 = 1'b1; s.mreq = ph; s.rd = ph;
                    end
                    TS_T2, TS_TW: begin
                        s.aoe = 1'b1; s.m1 = 1'b1; s.mreq = 1'b1; s.rd = 1'b1;
                    end
                    TS_T3: begin
                        s.aoe = 1'b1; s.rfsh = 1'b1; s.mreq = ph;
                    end
                    TS_T4: begin
                        s.aoe = 1'b1; s.rfsh = 1'b1; s.mreq = ~ph; s.done = ph;
                    end
                    default: ;
                endcase
            end
            CK_MWR: begin
                case (t)
                    TS_T1: begin
                        s.aoe = 1'b1; s.mreq = ph; s.doe = ph;
                    end
                    TS_T2: begin
                        s.aoe = 1'b1; s.mreq = 1'b1; s.doe = 1'b1; s.wr = ph;
                    end
                    TS_TW: begin
                        s.aoe = 1'b1; s.mreq = 1'b1; s.doe = 1'b1; s.wr = 1'b1;
                    end
                    TS_T3: begin
                        s.aoe = 1'b1; s.doe = 1'b1; s.mreq = ~ph; s.wr = ~ph;
                        s.done = ph;
                    end
                    default: ;
                endcase
            end
            CK_IORD: begin
                case (t)
                    TS_T1: s.aoe = 1'b1;
                    TS_T2, TS_TA1, TS_TW: begin
                        s.aoe = 1'b1; s.iorq = 1'b1; s.rd = 1'b1;
                    end
                    TS_T3: begin
                        s.aoe = 1'b1; s.iorq = ~ph; s.rd = ~ph; s.done = ph;
                    end
                    default: ;
                endcase
            end
            CK_IOWR: begin
                case (t)
                    TS_T1: begin
                        s.aoe = 1'b1; s.doe = ph;
                    end
                    TS_T2, TS_TA1, TS_TW: begin
                        s.aoe = 1'b1; s.doe = 1'b1; s.iorq = 1'b1; s.wr = 1'b1;
                    end
                    TS_T3: begin
                        s.aoe = 1'b1; s.doe = 1'b1; s.iorq = ~ph; s.wr = ~ph;
                        s.done = ph;
                    end
                    default: ;
                endcase
            end
            CK_INTA: begin
                case (t)
                    TS_T1, TS_T2, TS_TA1: begin
                        s.aoe = 1'b1; s.m1 = 1'b1;
                    end
                    TS_TA2, TS_TW: begin
                        s.aoe = 1'b1; s.m1 = 1'b1; s.iorq = 1'b1;
                    end
                    TS_T3: begin
                        s.aoe = 1'b1; s.m1 = ~ph; s.iorq = ~ph; s.done = ph;
                    end
                    default: ;
                endcase
            end
            default: begin // memory read
                case (t)
                    TS_T1: begin
                        s.aoe = 1'b1; s.mreq = ph; s.rd = ph;
                    end
                    TS_T2, TS_TW: begin
                        s.aoe = 1'b1; s.mreq = 1'b1; s.rd = 1'b1;
                    end
                    TS_T3: begin
                        s.aoe = 1'b1; s.mreq = ~ph; s.rd = ~ph; s.done = ph;
                    end
                    default: ;
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcs_tstate_ctrl.sv
module bcs_tstate_ctrl
    import bcs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  cyc_kind_e       kind,
    input  logic            wait_n,
    output tstate_e         tstate,
    output logic            ph,
    output logic            data_latch,
    output logic            rfsh_bump
);

    tstate_e t_q, t_d;
    logic    ph_q, ph_d;
    logic    last_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q  <= TS_IDLE;
            ph_q <= 1'b0;
        end else begin
            t_q  <= t_d;
            ph_q <= ph_d;
        end
    end

    always_comb begin
        t_d      = t_q;
        ph_d     = ~ph_q;
        last_pre = 1'b0;
        unique case (t_q)
            TS_IDLE: begin
                ph_d = 1'b0;
                if (start) t_d = TS_T1;
            end
            TS_T1: if (ph_q) t_d = TS_T2;
            TS_T2: begin
                if (ph_q) begin
                    if (kind_has_auto_wait(kind)) t_d = TS_TA1;
                    else last_pre = 1'b1;
                end
            end
            TS_TA1: begin
                if (ph_q) begin
                    if (kind == CK_INTA) t_d = TS_TA2;
                    else last_pre = 1'b1;
                end
            end
            TS_TA2: if (ph_q) last_pre = 1'b1;
            TS_TW:  if (ph_q) last_pre = 1'b1;
            TS_T3: begin
                if (ph_q) t_d = (kind == CK_FETCH) ? TS_T4 : TS_IDLE;
            end
            TS_T4: if (ph_q) t_d = TS_IDLE;
            default: t_d = TS_IDLE;
        endcase
        if (last_pre) t_d = wait_n ? TS_T3 : TS_TW;
    end

    // Fetch samples on the edge entering T3, others in the middle of T3.
    assign data_latch = (last_pre && wait_n && (kind == CK_FETCH)) ||
                        ((t_q == TS_T3) && !ph_q && kind_reads(kind));
    assign rfsh_bump  = (t_q == TS_T4) && ph_q;
    assign tstate     = t_q;
    assign ph         = ph_q;

    // R9: a wait state is only ever entered after a low wait sample
    p_tw_needs_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (t_q == TS_TW && !ph_q) |-> !$past(wait_n));

    // R8: the second automatic wait state belongs to acknowledge cycles only
    p_ta2_only_inta_r8: assert property (@(posedge clk) disable iff (rst)
        (t_q == TS_TA2) |-> (kind == CK_INTA));

    // R7: I/O and acknowledge cycles never skip the first automatic wait state
    p_auto_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (t_q == TS_T3 && !ph_q && kind_has_auto_wait(kind)) |->
        ($past(t_q) == TS_TA1 || $past(t_q) == TS_TA2 || $past(t_q) == TS_TW));

endmodule

// File: rtl/bcs_refresh_ctr.sv
module bcs_refresh_ctr #(
    parameter int RCNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bump,
    output logic [RCNT_W:0]   rcnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt <= '0;
        end else if (bump) begin
            rcnt <= {rcnt[RCNT_W], rcnt[RCNT_W-1:0] + 1'b1};
        end
    end

    // R4: low bits step by one per refresh, top bit untouched
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        bump |=> ((rcnt[RCNT_W-1:0] == RCNT_W'($past(rcnt[RCNT_W-1:0]) + 1'b1)) &&
                  (rcnt[RCNT_W] == $past(rcnt[RCNT_W]))));

    // R4: no movement without a completed refresh
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(rcnt));

endmodule

// File: rtl/bcs_bus_drive.sv
module bcs_bus_drive
    import bcs_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int RCNT_W = RCNT_W_DEF
) (
    input  cyc_kind_e           kind,
    input  tstate_e             tstate,
    input  logic                ph,
    input  logic [ADDR_W-1:0]   cyc_addr,
    input  logic [DATA_W-1:0]   cyc_wdata,
    input  logic [RCNT_W:0]     rcnt,
    output logic [ADDR_W-1:0]   addr,
    output logic                addr_oe,
    output logic [DATA_W-1:0]   dbus_out,
    output logic                dbus_oe,
    output logic                done,
    output logic                mreq_n,
    output logic                iorq_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic                m1_n,
    output logic                rfsh_n
);

    localparam int HI_W = ADDR_W - RCNT_W - 1;

    strobe_s s;

    always_comb begin
        s = strobe_table(kind, tstate, ph);
    end

    always_comb begin
        if (!s.aoe)       addr = '0;
        else if (s.rfsh)  addr = {{HI_W{1'b0}}, rcnt};
        else              addr = cyc_addr;
    end

    assign addr_oe  = s.aoe;
    assign dbus_oe  = s.doe;
    assign dbus_out = s.doe ? cyc_wdata : '0;
    assign done     = s.done;
    assign mreq_n   = ~s.mreq;
    assign iorq_n   = ~s.iorq;
    assign rd_n     = ~s.rd;
    assign wr_n     = ~s.wr;
    assign m1_n     = ~s.m1;
    assign rfsh_n   = ~s.rfsh;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int RCNT_W = RCNT_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [2:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                halt_i,
    input  logic                wait_n,
    input  logic [DATA_W-1:0]   dbus_in,
    output logic [DATA_W-1:0]   rdata,
    output logic                done,
    output logic [ADDR_W-1:0]   addr,
    output logic                addr_oe,
    output logic [DATA_W-1:0]   dbus_out,
    output logic                dbus_oe,
    output logic                mreq_n,
    output logic                iorq_n,
    output logic                rd_n,
    output logic                wr_n,
    output logic                m1_n,
    output logic                rfsh_n
);

    cyc_kind_e           kind_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    tstate_e             ts_w;
    logic                ph_w;
    logic                latch_w;
    logic                bump_w;
    logic                start_w;
    logic [RCNT_W:0]     rcnt_w;

    assign start_w = (ts_w == TS_IDLE) && (req_valid || halt_i);

    // Request capture: a halted core without a request gets a fetch.
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= CK_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start_w) begin
            kind_q  <= req_valid ? norm_kind(req_kind) : CK_FETCH;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (latch_w) rdata_q <= dbus_in;
    end
    assign rdata = rdata_q;

    bcs_tstate_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start_w),
        .kind       (kind_q),
        .wait_n     (wait_n),
        .tstate     (ts_w),
        .ph         (ph_w),
        .data_latch (latch_w),
        .rfsh_bump  (bump_w)
    );

    bcs_refresh_ctr #(.RCNT_W(RCNT_W)) u_rfsh (
        .clk  (clk),
        .rst  (rst),
        .bump (bump_w),
        .rcnt (rcnt_w)
    );

    bcs_bus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RCNT_W (RCNT_W)
    ) u_drive (
        .kind      (kind_q),
        .tstate    (ts_w),
        .ph        (ph_w),
        .cyc_addr  (addr_q),
        .cyc_wdata (wdata_q),
        .rcnt      (rcnt_w),
        .addr      (addr),
        .addr_oe   (addr_oe),
        .dbus_out  (dbus_out),
        .dbus_oe   (dbus_oe),
        .done      (done),
        .mreq_n    (mreq_n),
        .iorq_n    (iorq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .m1_n      (m1_n),
        .rfsh_n    (rfsh_n)
    );

    // R10: one clock after reset every strobe is idle and the buses released
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n &&
                 !addr_oe && !dbus_oe && !done));

    // R7: memory and I/O requests never overlap
    p_req_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(!mreq_n && !iorq_n));

    // R6: read and write strobes never overlap; write needs settled data
    p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    p_wr_after_data_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> (dbus_oe && $past(dbus_oe)));

    // R3: a refresh access never reads
    p_rfsh_no_rd_r3: assert property (@(posedge clk) disable iff (rst)
        !rfsh_n |-> rd_n);

    // R12: done lasts one clock and is followed by an idle clock
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && mreq_n && iorq_n && !addr_oe));

    // R9: everything on the bus holds during an inserted wait state
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (ts_w == TS_TW) |-> $stable({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n,
                                     addr, addr_oe, dbus_oe}));

    // R8: an acknowledge cycle never touches memory strobes
    p_inta_no_mem_r8: assert property (@(posedge clk) disable iff (rst)
        (kind_q == CK_INTA && ts_w != TS_IDLE) |-> (mreq_n && rd_n && wr_n));

endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        halt_i;
    logic        wait_n;
    logic [7:0]  dbus_in;
    logic [7:0]  rdata;
    logic        done;
    logic [15:0] addr;
    logic        addr_oe;
    logic [7:0]  dbus_out;
    logic        dbus_oe;
    logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [6:0]  rc_exp = 7'd0;

    always #10 clk = ~clk;

    bus_cycle_seq u_bus_cycle_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .halt_i    (halt_i),
        .wait_n    (wait_n),
        .dbus_in   (dbus_in),
        .rdata     (rdata),
        .done      (done),
        .addr      (addr),
        .addr_oe   (addr_oe),
        .dbus_out  (dbus_out),
        .dbus_oe   (dbus_oe),
        .mreq_n    (mreq_n),
        .iorq_n    (iorq_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .m1_n      (m1_n),
        .rfsh_n    (rfsh_n)
    );

    // T-state codes used by the bench: 1 T1, 2 T2, 3 TA1, 4 TA2, 5 TW, 6 T3, 7 T4
    // Result {mreq,iorq,rd,wr,m1,rfsh,aoe,doe,done}, active high, from R1..R12.
    function automatic logic [8:0] exp_st(int k, int t, bit ph);
        logic mq, io, rd, wr, m1, rf, ao, dq, dn;
        {mq, io, rd, wr, m1, rf, ao, dq, dn} = '0;
        case (k)
            0: case (t) // R1, R3, R12
                1: begin ao = 1; m1 = 1; mq = ph; rd = ph; end
                2, 5: begin ao = 1; m1 = 1; mq = 1; rd = 1; end
                6: begin ao = 1; rf = 1; mq = ph; end
                7: begin ao = 1; rf = 1; mq = !ph; dn = ph; end
                default: ;
            endcase
            2: case (t) // R6
                1: begin ao = 1; mq = ph; dq = ph; end
                2: begin ao = 1; mq = 1; dq = 1; wr = ph; end
                5: begin ao = 1; mq = 1; dq = 1; wr = 1; end
                6: begin ao = 1; dq = 1; mq = !ph; wr = !ph; dn = ph; end
                default: ;
            endcase
            3: case (t) // R7
                1: ao = 1;
                2, 3, 5: begin ao = 1; io = 1; rd = 1; end
                6: begin ao = 1; io = !ph; rd = !ph; dn = ph; end
                default: ;
            endcase
            4: case (t) // R7
                1: begin ao = 1; dq = ph; end
                2, 3, 5: begin ao = 1; dq = 1; io = 1; wr = 1; end
                6: begin ao = 1; dq = 1; io = !ph; wr = !ph; dn = ph; end
                default: ;
            endcase
            5: case (t) // R8
                1, 2, 3: begin ao = 1; m1 = 1; end
                4, 5: begin ao = 1; m1 = 1; io = 1; end
                6: begin ao = 1; m1 = !ph; io = !ph; dn = ph; end
                default: ;
            endcase
            default: case (t) // R5
                1: begin ao = 1; mq = ph; rd = ph; end
                2, 5: begin ao = 1; mq = 1; rd = 1; end
                6: begin ao = 1; mq = !ph; rd = !ph; dn = ph; end
                default: ;
            endcase
        endcase
        return {mq, io, rd, wr, m1, rf, ao, dq, dn};
    endfunction

    function automatic string kind_tag(int k);
        case (k)
            0: return "R1/R3";
            2: return "R6";
            3, 4: return "R7";
            5: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
        end
    endtask

    function automatic logic [8:0] act_st();
        return {~mreq_n, ~iorq_n, ~rd_n, ~wr_n, ~m1_n, ~rfsh_n, addr_oe, dbus_oe, done};
    endfunction

    // Called at a falling edge with the design idle; returns at a falling edge
    // of the idle clock that follows done.
    task automatic run_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] rdv, input int nwait, input bit by_halt);
        int ts[64];
        bit phs[64];
        int n = 0;
        int k = (kind > 5) ? 1 : kind;
        logic [8:0] e;
        ts[n] = 1; phs[n] = 0; n++; ts[n] = 1; phs[n] = 1; n++;
        ts[n] = 2; phs[n] = 0; n++; ts[n] = 2; phs[n] = 1; n++;
        if (k >= 3) begin ts[n] = 3; phs[n] = 0; n++; ts[n] = 3; phs[n] = 1; n++; end
        if (k == 5) begin ts[n] = 4; phs[n] = 0; n++; ts[n] = 4; phs[n] = 1; n++; end
        for (int w = 0; w < nwait; w++) begin
            ts[n] = 5; phs[n] = 0; n++; ts[n] = 5; phs[n] = 1; n++;
        end
        ts[n] = 6; phs[n] = 0; n++; ts[n] = 6; phs[n] = 1; n++;
        if (k == 0) begin ts[n] = 7; phs[n] = 0; n++; ts[n] = 7; phs[n] = 1; n++; end

        if (by_halt) begin
            halt_i = 1'b1; req_valid = 1'b0;
        end else begin
            req_valid = 1'b1;
        end
        req_kind = 3'(kind); req_addr = a; req_wdata = wd;
        wait_n = 1'b1; dbus_in = ~rdv;
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            int nxt;
            @(negedge clk);
            req_valid = 1'b0; halt_i = 1'b0;
            e = exp_st(k, ts[i], phs[i]);
            check(act_st() == e, by_halt ? "R11" : kind_tag(k), "strobes",
                  32'(act_st()), 32'(e));
            if (e[2]) begin
                logic [15:0] ea;
                ea = e[3] ? {8'h00, 1'b0, rc_exp} : a;
                check(addr == ea, e[3] ? "R3/R4" : kind_tag(k), "address",
                      32'(addr), 32'(ea));
            end
            if (e[1]) check(dbus_out == wd, "R6", "write data", 32'(dbus_out), 32'(wd));
            if (e[0] && (k == 0 || k == 1 || k == 3 || k == 5))
                check(rdata == rdv, (k == 0) ? "R2" : (k == 5) ? "R8" : "R5",
                      "read data", 32'(rdata), 32'(rdv));
            nxt = (i + 1 < n) ? ts[i+1] : 0;
            wait_n = (nxt == 5) ? 1'b0 : 1'b1;               // R9
            if ((k == 0 && nxt == 6 && ts[i] != 6) || (k != 0 && ts[i] == 6 && !phs[i]))
                dbus_in = rdv;
            else
                dbus_in = ~rdv;
            @(posedge clk);
        end
        if (k == 0) rc_exp = rc_exp + 7'd1;
        @(negedge clk);
        check(act_st() == 9'd0, "R12", "idle after done", 32'(act_st()), 32'd0);
        wait_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_wdata = '0;
        halt_i = 1'b0; wait_n = 1'b1; dbus_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(act_st() == 9'd0, "R10", "reset quiet", 32'(act_st()), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // Directed kinds, with and without waits
        run_cycle(0, 16'h1234, 8'h00, 8'h3E, 0, 0);
        run_cycle(0, 16'h1235, 8'h00, 8'hC9, 2, 0);   // R9 fetch waits
        run_cycle(1, 16'hBEEF, 8'h00, 8'h5A, 0, 0);
        run_cycle(1, 16'h8000, 8'h00, 8'hA5, 3, 0);   // R9
        run_cycle(2, 16'h4001, 8'h77, 8'h00, 0, 0);
        run_cycle(2, 16'h4002, 8'h88, 8'h00, 1, 0);   // R6 with wait
        run_cycle(3, 16'h00FE, 8'h00, 8'h11, 0, 0);
        run_cycle(4, 16'h0042, 8'h99, 8'h00, 2, 0);
        run_cycle(5, 16'h2000, 8'h00, 8'hFF, 0, 0);
        run_cycle(5, 16'h2001, 8'h00, 8'h38, 2, 0);   // R8 with waits
        run_cycle(6, 16'h0101, 8'h00, 8'h6C, 0, 0);   // R5 spare codes
        run_cycle(7, 16'h0202, 8'h00, 8'h93, 1, 0);
        // R11 halted fetches, back to back
        run_cycle(0, 16'h0076, 8'h00, 8'h00, 0, 1);
        run_cycle(0, 16'h0076, 8'h00, 8'h00, 0, 1);

        // Random mix
        for (int r = 0; r < 80; r++) begin
            int gap = $urandom % 3;
            run_cycle($urandom % 8, 16'($urandom), 8'($urandom), 8'($urandom),
                      $urandom % 3, 0);
            repeat (gap) @(negedge clk);
        end

        // R4 wrap of the refresh value past 127
        for (int f = 0; f < 130; f++) run_cycle(0, 16'(f), 8'h00, 8'(f), 0, 0);

        // R10 reset in mid-cycle, then refresh value restarts at 0
        req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h5555; req_wdata = 8'h12;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(act_st() == 9'd0, "R10", "quiet after mid-cycle reset", 32'(act_st()), 32'd0);
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0; rc_exp = 7'd0;
        @(negedge clk);
        run_cycle(0, 16'h0300, 8'h00, 8'h44, 0, 0);
        run_cycle(0, 16'h0301, 8'h00, 8'h45, 1, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule